// File: doc/BRIEF.md
# Abort and Reset Pulse Discriminator

This block watches a shared, active-low abort wire and decides, purely from how many consecutive clocks the wire stays low, which of two meanings a low pulse carries. A low that begins while the bus cycle sits in its address-translation state or its float (suspended) state is an abort request: the block emits a one-clock abort pulse and blocks the physical-address-valid strobe for the rest of that cycle, so the aborted cycle never becomes visible on the bus. A low that persists for a long run of clocks is a system reset, reported as a level that stays up until the wire is released.

The block also owns an open-drain pull on the same wire. When its external reset request is asserted, it pulls the wire low for a minimum run long enough to be recognised as a reset by every listener, so the reset propagates to the processor over the abort wire. Its own pull is never mistaken for an abort. The wire is expected to be a wired-AND of all pullers; the block reads the resolved level back on `abt_line_n`.

Top module: `abort_reset_discrim`

## Requirements
- R1: While and right after `rst_n` is low, `abort_pulse`, `reset_level` and `line_pull` are 0 and `pav_out` equals `pav_req`.
- R2: When a clock edge samples `abt_line_n` low after a high sample (first low of a run) and `bus_phase` is 2 (translation) or 3 (float) on a 3-bit phase code, `abort_pulse` is 1 for exactly the one cycle after that edge.
- R3: A first low sampled in any other phase code, and every later low sample of the same run, produce no `abort_pulse`.
- R4: `reset_level` is 1 in the cycle after the edge that samples the 64th consecutive low, stays 1 while samples stay low, and drops after the first high sample; a single high sample restarts the count, so two runs of 63 lows separated by one high never raise it.
- R5: `line_pull` is 1 from the cycle after the first edge that samples `ext_reset` high, and stays 1 for 63 cycles after the last such edge, giving k+63 cycles for k consecutive sampled edges (at least 64).
- R6: A low run that starts while the block itself is pulling the wire produces no `abort_pulse`, even in phase 2 or 3; the run still counts toward `reset_level`.
- R7: `pav_out` is `pav_req` except that it is 0 from the cycle after an abort edge until the cycle after an edge that samples `cyc_end` high, and 0 whenever `reset_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| abt_line_n | input | 1 | Resolved level of the shared active-low abort wire |
| bus_phase | input | 3 | Current bus-cycle state code (2 translation, 3 float) |
| ext_reset | input | 1 | Active-high request to broadcast a reset over the wire |
| pav_req | input | 1 | Physical-address-valid strobe from the cycle logic |
| cyc_end | input | 1 | Marks the last clock of the current bus cycle |
| abort_pulse | output | 1 | One-clock abort indication |
| reset_level | output | 1 | High while a reset-length low is in progress |
| line_pull | output | 1 | Open-drain enable: 1 pulls the abort wire low |
| pav_out | output | 1 | Gated physical-address-valid strobe |

## Verification
The bench sweeps every phase code with short lows and runs of length 1, 2, 63, 64, 65 and 70, checking each cycle, so a counter that is off by one would raise the reset level a clock early or late, and a window decode that is too wide would abort in idle states. Two 63-clock runs separated by a single high sample catch a counter that fails to clear. Self-driven resets of one and ten clocks check the pull length and that the block's own drive, seen in the translation state, never aborts. The strobe gate is checked across abort, cycle end and a reset-length low, which a design that forgot to hold or release the kill would get wrong.

// File: rtl/ard_pkg.sv
package ard_pkg;
   localparam int DEF_PHASE_W    = 3;
   localparam int DEF_XLAT_CODE  = 2;
   localparam int DEF_FLOAT_CODE = 3;
   localparam int DEF_RUN_LEN    = 64;
   localparam int DEF_DRIVE_LEN  = 64;

   typedef struct packed {
      logic abort;
      logic long_low;
   } ard_evt_t;
endpackage

// File: rtl/ard_line_sync.sv
module ard_line_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   generate
      if (STAGES == 0) begin : g_direct
         assign line_o = line_i;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '1;
            end else begin
               sr[0] <= line_i;
               for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign line_o = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ard_low_run.sv
module ard_low_run #(
   parameter int RUN_LEN = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic low,
   output logic first_low,
   output logic long_low
);
   localparam int RUN_W = $clog2(RUN_LEN + 1);
   localparam logic [RUN_W-1:0] SAT  = RUN_W'(RUN_LEN);
   localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

   logic [RUN_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!low)       cnt <= '0;
      else if (cnt != SAT) cnt <= cnt + 1'b1;
   end

   assign first_low = low && (cnt == '0);
   assign long_low  = low && (cnt >= LAST);
endmodule

// File: rtl/ard_drive_timer.sv
module ard_drive_timer #(
   parameter int DRIVE_LEN = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic pull
);
   localparam int DRV_W = $clog2(DRIVE_LEN + 1);
   localparam logic [DRV_W-1:0] LOAD = DRV_W'(DRIVE_LEN);

   logic [DRV_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          left <= '0;
      else if (req)        left <= LOAD;
      else if (left != '0) left <= left - 1'b1;
   end

   assign pull = (left != '0);
endmodule

// File: rtl/abort_reset_discrim.sv
module abort_reset_discrim
   import ard_pkg::*;
#(
   parameter int PHASE_W     = DEF_PHASE_W,
   parameter int XLAT_CODE   = DEF_XLAT_CODE,
   parameter int FLOAT_CODE  = DEF_FLOAT_CODE,
   parameter int RUN_LEN     = DEF_RUN_LEN,
   parameter int DRIVE_LEN   = DEF_DRIVE_LEN,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               abt_line_n,
   input  logic [PHASE_W-1:0] bus_phase,
   input  logic               ext_reset,
   input  logic               pav_req,
   input  logic               cyc_end,
   output logic               abort_pulse,
   output logic               reset_level,
   output logic               line_pull,
   output logic               pav_out
);
   localparam logic [PHASE_W-1:0] XLAT_P  = PHASE_W'(XLAT_CODE);
   localparam logic [PHASE_W-1:0] FLOAT_P = PHASE_W'(FLOAT_CODE);

   generate
      if (RUN_LEN < 2) begin : g_bad_run
         $error("RUN_LEN must be at least 2");
      end
      if (DRIVE_LEN < RUN_LEN) begin : g_bad_drive
         $error("DRIVE_LEN must not be shorter than RUN_LEN");
      end
      if (XLAT_CODE >= (1 << PHASE_W) || FLOAT_CODE >= (1 << PHASE_W)) begin : g_bad_code
         $error("phase codes do not fit PHASE_W");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be non-negative");
      end
   endgenerate

   logic     line_s;
   logic     first_low;
   logic     long_low;
   logic     in_window;
   logic     kill_q;
   ard_evt_t evt;
   ard_evt_t evt_q;

   ard_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (abt_line_n),
      .line_o (line_s)
   );

   ard_low_run #(.RUN_LEN(RUN_LEN)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .low       (!line_s),
      .first_low (first_low),
      .long_low  (long_low)
   );

   ard_drive_timer #(.DRIVE_LEN(DRIVE_LEN)) u_drive (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ext_reset),
      .pull  (line_pull)
   );

   assign in_window    = (bus_phase == XLAT_P) || (bus_phase == FLOAT_P);
   assign evt.abort    = first_low && in_window && !line_pull;
   assign evt.long_low = long_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         kill_q <= 1'b0;
      end else begin
         evt_q <= evt;
         if (evt.abort)    kill_q <= 1'b1;
         else if (cyc_end) kill_q <= 1'b0;
      end
   end

   assign abort_pulse = evt_q.abort;
   assign reset_level = evt_q.long_low;
   assign pav_out     = pav_req && !kill_q && !evt_q.long_low;
endmodule

// File: rtl/ard_checker.sv
module ard_checker #(
   parameter int PHASE_W    = 3,
   parameter int XLAT_CODE  = 2,
   parameter int FLOAT_CODE = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               line_s,
   input logic [PHASE_W-1:0] bus_phase,
   input logic               ext_reset,
   input logic               pav_req,
   input logic               abort_pulse,
   input logic               reset_level,
   input logic               line_pull,
   input logic               pav_out
);
   logic win;
   assign win = (bus_phase == PHASE_W'(XLAT_CODE)) || (bus_phase == PHASE_W'(FLOAT_CODE));

   assert_abort_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |=> !abort_pulse);

   assert_abort_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> ($past(!line_s) && $past(win)));

   assert_no_self_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> !$past(line_pull));

   assert_reset_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reset_level |-> $past(!line_s));

   assert_pull_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull) |-> $past(ext_reset));

   assert_pull_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_reset |=> line_pull);

   assert_pav_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pav_out |-> (pav_req && !reset_level));
endmodule

bind abort_reset_discrim ard_checker #(
   .PHASE_W    (PHASE_W),
   .XLAT_CODE  (XLAT_CODE),
   .FLOAT_CODE (FLOAT_CODE)
) u_ard_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_s      (line_s),
   .bus_phase   (bus_phase),
   .ext_reset   (ext_reset),
   .pav_req     (pav_req),
   .abort_pulse (abort_pulse),
   .reset_level (reset_level),
   .line_pull   (line_pull),
   .pav_out     (pav_out)
);

// File: tb/tb_abort_reset_discrim.sv
`timescale 1ns/1ps
module tb_abort_reset_discrim;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tb_pull = 1'b0;
   logic [2:0] bus_phase = 3'd0;
   logic       ext_reset = 1'b0;
   logic       pav_req = 1'b0;
   logic       cyc_end = 1'b0;
   logic       abt_line_n;
   logic       abort_pulse, reset_level, line_pull, pav_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   assign abt_line_n = !(line_pull || tb_pull);

   abort_reset_discrim dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .abt_line_n  (abt_line_n),
      .bus_phase   (bus_phase),
      .ext_reset   (ext_reset),
      .pav_req     (pav_req),
      .cyc_end     (cyc_end),
      .abort_pulse (abort_pulse),
      .reset_level (reset_level),
      .line_pull   (line_pull),
      .pav_out     (pav_out)
   );

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Hold the wire low for n sampled edges in phase ph, then release.
   task automatic low_run(int n, logic [2:0] ph);
      bit win = (ph == 3'd2) || (ph == 3'd3);
      bus_phase = ph;
      tb_pull = 1'b1;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         check("R4 level during run", int'(reset_level), int'(i >= 64));
         if (win && i == 1) check("R2 abort on first low", int'(abort_pulse), 1);
         else               check("R3 no abort", int'(abort_pulse), 0);
      end
      tb_pull = 1'b0;
      @(negedge clk);
      check("R4 cleared by high", int'(reset_level), 0);
      check("R3 no abort after run", int'(abort_pulse), 0);
   endtask

   // Broadcast a reset with ext_reset sampled on k edges.
   task automatic self_reset(int k);
      int pulls = 0;
      int aborts = 0;
      int lvls = 0;
      bus_phase = 3'd2;
      ext_reset = 1'b1;
      for (int i = 1; i <= 160; i++) begin
         @(negedge clk);
         if (i == 1) check("R5 pull starts", int'(line_pull), 1);
         if (line_pull) pulls++;
         if (abort_pulse) aborts++;
         if (reset_level) lvls++;
         if (i == k) ext_reset = 1'b0;
      end
      check("R5 pull length", pulls, k + 63);
      check("R6 no self abort", aborts, 0);
      check("R6 self drive seen as reset", lvls, k);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      pav_req = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 abort in reset", int'(abort_pulse), 0);
      check("R1 level in reset", int'(reset_level), 0);
      check("R1 pull in reset", int'(line_pull), 0);
      check("R1 pav in reset", int'(pav_out), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 abort after reset", int'(abort_pulse), 0);
      check("R1 pull after reset", int'(line_pull), 0);
      check("R7 pav passes", int'(pav_out), 1);
      pav_req = 1'b0;

      // every phase code, short lows
      for (int p = 0; p < 8; p++) begin
         low_run(1, 3'(p));
         low_run(2, 3'(p));
         @(negedge clk);
      end
      // run lengths around the reset threshold
      low_run(63, 3'd0);
      low_run(64, 3'd3);
      low_run(65, 3'd1);
      low_run(70, 3'd2);
      // 63 low, one high, 63 low: never a reset (R4)
      low_run(63, 3'd5);
      low_run(63, 3'd5);
      repeat (2) @(negedge clk);

      // self-driven resets
      self_reset(1);
      self_reset(10);
      bus_phase = 3'd0;
      @(negedge clk);

      // strobe suppression across an abort (R7)
      bus_phase = 3'd2;
      tb_pull = 1'b1;
      @(negedge clk);
      tb_pull = 1'b0;
      check("R2 abort in translation", int'(abort_pulse), 1);
      pav_req = 1'b1;
      bus_phase = 3'd4;
      @(negedge clk);
      check("R7 pav killed", int'(pav_out), 0);
      @(negedge clk);
      check("R7 pav still killed", int'(pav_out), 0);
      cyc_end = 1'b1;
      @(negedge clk);
      cyc_end = 1'b0;
      check("R7 pav restored after cycle end", int'(pav_out), 1);
      // strobe blocked during a reset-length low
      tb_pull = 1'b1;
      bus_phase = 3'd0;
      for (int i = 1; i <= 66; i++) begin
         @(negedge clk);
         check("R7 pav vs reset level", int'(pav_out), int'(i < 64));
      end
      tb_pull = 1'b0;
      @(negedge clk);
      check("R7 pav after release", int'(pav_out), 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule